// File: doc/BRIEF.md
# Timer Mode, Prescaler and Capture Control

This block sits beside a pair of timer counters and a capture unit and decides when each of them acts. An 8-bit mode register picks the count source of the first counter unit and of the third counter unit. Each unit can count on rising edges of an external signal or on taps of one shared prescaler that runs on the system clock. The register also picks the trigger that copies a 16-bit counter value into a capture holding register. The block produces one-cycle count-enable strobes, the captured value, two sticky status flags and a single interrupt request.

One mode bit (`cpSlm`) does two jobs. While it is 0, capture events set the capture flag, and the interrupt follows that flag. While it is 1, the one-cycle end-of-mono-multi pulse sets the mono flag instead, and the interrupt follows the mono flag. Software clears a flag in two steps. It first reads the register while the flag is 1, and then it writes 0 to that bit. The three external inputs are asynchronous. Each one passes through a two-flop synchroniser and a rising-edge detector.

Top module: `tmr_mode_ctl`

## Requirements
- R1: After reset, the mode register reads 0x00, `irqReq` is 0 and `capValue` is 0.
- R2: Field bits 6:5 pick the source of `unit1CountEn`. 00 gives one pulse per rising edge of `refEdgeIn`. 01 gives one pulse every 4 clocks, 10 one pulse every 256 clocks and 11 one pulse every 512 clocks.
- R3: Field bits 4:3 pick the source of `unit3CountEn`. 00 gives one pulse per rising edge of `divEdgeIn`. 01 gives one pulse every 4096 clocks, 10 one pulse every 2048 clocks and 11 one pulse every 1024 clocks.
- R4: While bit 7 is 0, a `unit3Underflow` pulse triggers a capture. `capSrcSel` has no effect, and edges on `refEdgeIn` and `extTrigIn` capture nothing.
- R5: While bit 7 is 1, a rising edge of `refEdgeIn` triggers a capture when `capSrcSel` is 0, and a rising edge of `extTrigIn` triggers one when `capSrcSel` is 1. The source that is not selected, and `unit3Underflow`, capture nothing.
- R6: A capture loads `cntValue` into `capValue` on the clock edge of the trigger. At all other times `capValue` holds its value.
- R7: Bit 1 (capture flag) sets on a capture event while bit 2 is 0. A capture event while bit 2 is 1 leaves it unchanged.
- R8: Bit 0 (mono flag) sets on a `monoEndPulse` while bit 2 is 1. The same pulse while bit 2 is 0 leaves it unchanged.
- R9: A flag clears only on a write of 0 to its bit, and only after a read of the register that returned the flag as 1. A write of 0 with no such read leaves the flag set, and so does a write of 1.
- R10: If a flag's set event falls in the same cycle as a valid clearing write, the flag stays 1. The earlier read no longer counts, so a later write of 0 needs a new read first.
- R11: `irqReq` equals bit 1 while bit 2 is 0, and equals bit 0 while bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Mode register contents |
| capSrcSel | input | 1 | Picks the capture edge source when bit 7 is 1 |
| refEdgeIn | input | 1 | Asynchronous reference signal, used for counting and capture |
| divEdgeIn | input | 1 | Asynchronous divider output, used for third-unit counting |
| extTrigIn | input | 1 | Asynchronous external capture trigger |
| unit3Underflow | input | 1 | One-cycle underflow pulse from the third counter |
| monoEndPulse | input | 1 | One-cycle end-of-mono-multi pulse |
| cntValue | input | 16 | Counter value to capture |
| unit1CountEn | output | 1 | One-cycle count enable for the first unit |
| unit3CountEn | output | 1 | One-cycle count enable for the third unit |
| capValue | output | 16 | Captured counter value |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench counts enable pulses over an 8192-cycle window for every clock-select code. A design with a tap on the wrong prescaler bit, or with the select codes swapped, gives the wrong count. For each capture mode the bench triggers the selected source and also the sources that are not selected, and each trigger uses a different counter value. A decoder that looks at `capSrcSel` while bit 7 is 0 therefore shows up as an unexpected change of `capValue`. The flag tests try a write of 0 with no read, a write of 1 after a read, and a set that collides with a valid clear. Each of these catches a flag that clears too easily, or a read that is still counted after the flag sets again.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       latchNow;
    logic [1:0] u1Sel;
    logic [1:0] u3Sel;
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], asyncIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign risePulse = syncQ[STAGES-1] & ~prevQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12,
  parameter int U1_T1  = 2,
  parameter int U1_T2  = 8,
  parameter int U1_T3  = 9,
  parameter int U3_T1  = 12,
  parameter int U3_T2  = 11,
  parameter int U3_T3  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic             refRise,
  input  logic             divRise,
  input  logic [CNT_W-1:0] cntValue,
  output logic             unit1CountEn,
  output logic             unit3CountEn,
  output logic [CNT_W-1:0] capValue
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:1]   tapHit;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // tapHit[k] pulses once every 2**k cycles, when the low k bits wrap
  for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
    assign tapHit[k] = &preCnt[k-1:0];
  end

  always_comb begin
    unique case (strobes.u1Sel)
      2'd0:    unit1CountEn = refRise;
      2'd1:    unit1CountEn = tapHit[U1_T1];
      2'd2:    unit1CountEn = tapHit[U1_T2];
      default: unit1CountEn = tapHit[U1_T3];
    endcase
    unique case (strobes.u3Sel)
      2'd0:    unit3CountEn = divRise;
      2'd1:    unit3CountEn = tapHit[U3_T1];
      2'd2:    unit3CountEn = tapHit[U3_T2];
      default: unit3CountEn = tapHit[U3_T3];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 capValue <= '0;
    else if (strobes.latchNow) capValue <= cntValue;
  end
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  input  logic        capSrcSel,
  input  logic        refRise,
  input  logic        extRise,
  input  logic        unit3Underflow,
  input  logic        monoEndPulse,
  output tmrStrobes_t strobes,
  output logic [7:0]  rdData,
  output logic        irqReq
);
  localparam int NFLAG = 2;  // index 1: capture flag, index 0: mono flag

  logic             latchSel;
  logic [1:0]       u1Sel;
  logic [1:0]       u3Sel;
  logic             cpSlm;
  logic [NFLAG-1:0] flagQ;
  logic [NFLAG-1:0] armedQ;
  logic [NFLAG-1:0] setEv;
  logic             capTrig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchSel <= 1'b0;
      u1Sel    <= 2'd0;
      u3Sel    <= 2'd0;
      cpSlm    <= 1'b0;
    end else if (busWrEn) begin
      latchSel <= busWrData[7];
      u1Sel    <= busWrData[6:5];
      u3Sel    <= busWrData[4:3];
      cpSlm    <= busWrData[2];
    end
  end

  always_comb begin
    if (latchSel) capTrig = capSrcSel ? extRise : refRise;
    else          capTrig = unit3Underflow;
  end

  assign setEv[1] = capTrig & ~cpSlm;
  assign setEv[0] = monoEndPulse & cpSlm;

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[f]  <= 1'b0;
        armedQ[f] <= 1'b0;
      end else if (setEv[f]) begin
        flagQ[f]  <= 1'b1;
        armedQ[f] <= 1'b0;
      end else if (busWrEn && !busWrData[f] && armedQ[f]) begin
        flagQ[f]  <= 1'b0;
        armedQ[f] <= 1'b0;
      end else if (busRdEn && flagQ[f]) begin
        armedQ[f] <= 1'b1;
      end
    end
  end

  assign strobes.latchNow = capTrig;
  assign strobes.u1Sel    = u1Sel;
  assign strobes.u3Sel    = u3Sel;
  assign rdData           = {latchSel, u1Sel, u3Sel, cpSlm, flagQ};
  assign irqReq           = cpSlm ? flagQ[0] : flagQ[1];
endmodule

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic             capSrcSel,
  input  logic             refEdgeIn,
  input  logic             divEdgeIn,
  input  logic             extTrigIn,
  input  logic             unit3Underflow,
  input  logic             monoEndPulse,
  input  logic [CNT_W-1:0] cntValue,
  output logic             unit1CountEn,
  output logic             unit3CountEn,
  output logic [CNT_W-1:0] capValue,
  output logic             irqReq
);
  localparam int NSRC = 3;

  logic [NSRC-1:0] rawIn;
  logic [NSRC-1:0] risePulse;
  tmrStrobes_t     strobes;

  assign rawIn = {extTrigIn, divEdgeIn, refEdgeIn};

  for (genvar s = 0; s < NSRC; s++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .asyncIn(rawIn[s]), .risePulse(risePulse[s])
    );
  end

  tmr_control u_ctl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .capSrcSel(capSrcSel),
    .refRise(risePulse[0]), .extRise(risePulse[2]),
    .unit3Underflow(unit3Underflow), .monoEndPulse(monoEndPulse),
    .strobes(strobes), .rdData(busRdData), .irqReq(irqReq)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .refRise(risePulse[0]), .divRise(risePulse[1]),
    .cntValue(cntValue), .unit1CountEn(unit1CountEn),
    .unit3CountEn(unit3CountEn), .capValue(capValue)
  );
endmodule

// File: rtl/tmr_mode_ctl_chk.sv
module tmr_mode_ctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [7:0]       busWrData,
  input logic [7:0]       busRdData,
  input logic             unit3Underflow,
  input logic             monoEndPulse,
  input logic [CNT_W-1:0] cntValue,
  input logic [CNT_W-1:0] capValue,
  input logic             irqReq
);
  p_underflow_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdData[7] && unit3Underflow) |=> capValue == $past(cntValue));

  p_capflag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdData[7] && unit3Underflow && !busRdData[2]) |=> busRdData[1]);

  p_monoflag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (monoEndPulse && busRdData[2]) |=> busRdData[0]);

  p_capflag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdData[1]) |-> ($past(busWrEn) && !$past(busWrData[1])));

  p_monoflag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdData[0]) |-> ($past(busWrEn) && !$past(busWrData[0])));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (busRdData[2] ? busRdData[0] : busRdData[1]));
endmodule

bind tmr_mode_ctl tmr_mode_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
  .busRdData(busRdData), .unit3Underflow(unit3Underflow),
  .monoEndPulse(monoEndPulse), .cntValue(cntValue), .capValue(capValue),
  .irqReq(irqReq)
);

// File: tb/tmr_mode_ctl_test.sv
`timescale 1ns/1ps
module tmr_mode_ctl_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn, busRdEn;
  logic [7:0]  busWrData;
  logic [7:0]  busRdData;
  logic        capSrcSel, refEdgeIn, divEdgeIn, extTrigIn;
  logic        unit3Underflow, monoEndPulse;
  logic [15:0] cntValue;
  logic        unit1CountEn, unit3CountEn;
  logic [15:0] capValue;
  logic        irqReq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expQ[$];
  logic [15:0] lastCap = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_mode_ctl uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .capSrcSel(capSrcSel),
    .refEdgeIn(refEdgeIn), .divEdgeIn(divEdgeIn), .extTrigIn(extTrigIn),
    .unit3Underflow(unit3Underflow), .monoEndPulse(monoEndPulse),
    .cntValue(cntValue), .unit1CountEn(unit1CountEn),
    .unit3CountEn(unit3CountEn), .capValue(capValue), .irqReq(irqReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every change of capValue must match the queue head
  always @(negedge clk) begin
    if (rstN && capValue != lastCap) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected capture actual=0x%0h expected=0x%0h", capValue, lastCap);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        if (capValue != e) begin
          fails++;
          $display("FAIL R6 capture actual=0x%0h expected=0x%0h", capValue, e);
        end
      end
      lastCap = capValue;
    end
  end

  task automatic wrReg(input logic [7:0] d, input logic uf = 1'b0);
    busWrEn = 1'b1; busWrData = d; unit3Underflow = uf;
    @(negedge clk);
    busWrEn = 1'b0; unit3Underflow = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdReg();
    busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic underflow(input logic [15:0] v, input logic expect_cap);
    cntValue = v;
    if (expect_cap) expQ.push_back(v);
    unit3Underflow = 1'b1;
    @(negedge clk);
    unit3Underflow = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // which: 0 ref, 1 div, 2 ext; 3 cycles high then 3 low
  task automatic extPulse(input int which, input logic [15:0] v, input logic expect_cap);
    cntValue = v;
    if (expect_cap) expQ.push_back(v);
    if (which == 0) refEdgeIn = 1'b1;
    else if (which == 1) divEdgeIn = 1'b1;
    else extTrigIn = 1'b1;
    repeat (3) @(negedge clk);
    refEdgeIn = 1'b0; divEdgeIn = 1'b0; extTrigIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic countWin(input int n, output int c1, output int c3);
    c1 = 0; c3 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (unit1CountEn) c1++;
      if (unit3CountEn) c3++;
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c1, c3;
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busWrData = '0;
    capSrcSel = 1'b0; refEdgeIn = 1'b0; divEdgeIn = 1'b0; extTrigIn = 1'b0;
    unit3Underflow = 1'b0; monoEndPulse = 1'b0; cntValue = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    check("R1 mode reg", busRdData, 8'h00);
    check("R1 irqReq", irqReq, 0);
    check("R1 capValue", capValue, 0);

    // R2 / R3 prescaler taps, fields 6:5 and 4:3 set to the same code
    for (int s = 1; s < 4; s++) begin
      wrReg({1'b0, s[1:0], s[1:0], 3'b000});
      countWin(8192, c1, c3);
      check("R2 unit1 tap count", c1, (s == 1) ? 2048 : (s == 2) ? 32 : 16);
      check("R3 unit3 tap count", c3, (s == 1) ? 2 : (s == 2) ? 4 : 8);
    end
    // external edge sources
    wrReg(8'h00);
    repeat (4) @(negedge clk);
    c1 = 0; c3 = 0;
    for (int k = 0; k < 10; k++) begin
      refEdgeIn = 1'b1; divEdgeIn = 1'b1;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk); if (unit1CountEn) c1++; if (unit3CountEn) c3++;
      end
      refEdgeIn = 1'b0; divEdgeIn = 1'b0;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk); if (unit1CountEn) c1++; if (unit3CountEn) c3++;
      end
    end
    check("R2 unit1 ref edges", c1, 10);
    check("R3 unit3 div edges", c3, 10);

    // R4: latch bit 0 -> underflow only, capSrcSel ignored
    capSrcSel = 1'b1;
    underflow(16'h1234, 1'b1);
    extPulse(0, 16'h5555, 1'b0);
    extPulse(2, 16'h6666, 1'b0);
    check("R4 capValue after ignored edges", capValue, 16'h1234);
    check("R7 capflag set", busRdData[1], 1);
    check("R11 irq follows capflag", irqReq, 1);

    // R5: latch bit 1
    wrReg(8'h80);
    capSrcSel = 1'b0;
    extPulse(0, 16'hA001, 1'b1);
    extPulse(2, 16'hBEEF, 1'b0);
    underflow(16'h7777, 1'b0);
    check("R5 ref-edge capture", capValue, 16'hA001);
    capSrcSel = 1'b1;
    extPulse(2, 16'hC0DE, 1'b1);
    extPulse(0, 16'hD00D, 1'b0);
    underflow(16'h8888, 1'b0);
    check("R5 ext-edge capture", capValue, 16'hC0DE);

    // R9: clear protocol on capture flag (set above, never read)
    wrReg(8'h00);
    check("R9 write 0 without read keeps flag", busRdData[1], 1);
    rdReg();
    wrReg(8'h02);
    check("R9 write 1 keeps flag", busRdData[1], 1);
    wrReg(8'h00);
    check("R9 read then write 0 clears", busRdData[1], 0);
    check("R11 irq low after clear", irqReq, 0);

    // R7 negative, R8 positive with cpSlm = 1
    wrReg(8'h04);
    underflow(16'h0777, 1'b1);
    check("R7 capflag not set when cpSlm=1", busRdData[1], 0);
    check("R11 irq low", irqReq, 0);
    @(negedge clk);
    monoEndPulse = 1'b1; @(negedge clk); monoEndPulse = 1'b0; @(negedge clk);
    check("R8 monoflag set", busRdData, 8'h05);
    check("R11 irq follows monoflag", irqReq, 1);
    wrReg(8'h01);
    check("R11 irq follows capflag when cpSlm=0", irqReq, 0);
    rdReg();
    wrReg(8'h04);
    check("R9 monoflag cleared", busRdData[0], 0);
    wrReg(8'h00);
    monoEndPulse = 1'b1; @(negedge clk); monoEndPulse = 1'b0; @(negedge clk);
    check("R8 monoflag not set when cpSlm=0", busRdData[0], 0);

    // R10: set collides with a valid clear
    underflow(16'h0999, 1'b1);
    rdReg();
    cntValue = 16'h0AAA; expQ.push_back(16'h0AAA);
    wrReg(8'h00, 1'b1);
    check("R10 set wins over clear", busRdData[1], 1);
    wrReg(8'h00);
    check("R10 earlier read no longer counts", busRdData[1], 1);
    rdReg();
    wrReg(8'h00);
    check("R10 fresh read then clear", busRdData[1], 0);

    repeat (4) @(negedge clk);
    check("R6 all expected captures seen", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule